// File: doc/BRIEF.md
# Single-Line External Interrupt Controller

The block watches one external interrupt pin. It turns the events it detects into one active-high level request for a parent interrupt controller. The pin is first resynchronised into the block clock domain. A two-bit sense field then chooses how the pin is interpreted: as a low level, a high level, a falling edge or a rising edge. Every detected event sets a sticky pending flag. Software clears that flag by writing a one to it. The request output is the pending flag gated by an enable bit, and the flag keeps latching while the output is gated off.

Software reaches the block through a plain 32-bit register port: an address, a write strobe, write data and combinational read data. There are three registers: sense control, pending and enable. A parameter picks one of two address layouts, so the same RTL fits either address map of a neighbouring bus fabric. The usual driver flow is as follows. Program the sense field with a read-modify-write, clear any stale pending flag, then set the enable bit. In the handler, write one to the pending flag once the source has been serviced.

Top module: `exti_ctrl`

## Requirements
- R1: After reset, with the pin held high, every register reads zero and `irq_o` is low.
- R2: Control bits [1:0] select the sense mode. The encoding is 0 = low level, 1 = falling edge, 2 = high level, 3 = rising edge.
- R3: In an edge mode, only a transition in the selected direction sets the pending flag. A transition in the other direction has no effect.
- R4: In a level mode, the pending flag is set on every cycle in which the selected level persists. A clear written while the level is still present leaves the flag set. A clear written after the level has gone away removes it.
- R5: Pending register bit 0 is the pending flag and is write-one-to-clear. Writing zero to it leaves the flag unchanged. Pending bits [31:1] read zero.
- R6: When a detected event and a clearing write fall in the same cycle, the flag stays set.
- R7: `irq_o` is high exactly when the pending flag and enable bit 0 are both set. The flag still latches events while enable bit 0 is zero.
- R8: The control and enable registers read back all 32 bits exactly as last written.
- R9: With `LAYOUT` = 0, control, pending and enable sit at byte offsets 0x00, 0x04 and 0x08. With `LAYOUT` = 1, they sit at 0x0C, 0x10 and 0x40.
- R10: An address that maps to no register reads zero, and a write to it changes no register.
- R11: A pin change made between two clock edges reaches `irq_o` on the third rising edge after it, and not before. This follows from a two-flop synchronizer plus the pending flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | External interrupt pin, asynchronous to clk_i |
| addr_i | input | ADDR_W (8) | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Active-high level request to the parent controller |

## Verification
The pin is driven in each of the four sense modes with both transition directions. A transition against the chosen direction must leave the flag clear, which separates the two edge modes from each other and from the level modes. Level modes are also tried with a clear written while the level is still held and again after it has dropped, which separates persistent re-setting from edge latching. A clear placed in the exact cycle of an edge event shows whether the event or the clear takes priority. A second instance on the alternative layout, driven by the same bus writes, shows which offsets each layout decodes and which it ignores.

// File: rtl/exti_pkg.sv
package exti_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SENSE_LVL_LO    = 2'd0,
    SENSE_EDGE_FALL = 2'd1,
    SENSE_LVL_HI    = 2'd2,
    SENSE_EDGE_RISE = 2'd3
  } sense_e;

  typedef enum int {
    REG_CTRL = 0,
    REG_PEND = 1,
    REG_EN   = 2
  } reg_idx_e;

  // byte offset of a register for the chosen address layout
  function automatic int reg_offset(int layout, reg_idx_e idx);
    if (layout == 0) begin
      case (idx)
        REG_CTRL: return 'h00;
        REG_PEND: return 'h04;
        default:  return 'h08;
      endcase
    end else begin
      case (idx)
        REG_CTRL: return 'h0C;
        REG_PEND: return 'h10;
        default:  return 'h40;
      endcase
    end
  endfunction

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= RST_VAL;
          else         stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= RST_VAL;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/exti_detect.sv
module exti_detect
  import exti_pkg::*;
#(
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sync_i,
  input  sense_e mode_i,
  input  logic   clr_i,
  output logic   pend_o
);

  logic prev_q;
  logic pend_q;
  logic evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE_VAL;
    else         prev_q <= sync_i;
  end

  always_comb begin
    unique case (mode_i)
      SENSE_LVL_LO:    evt = ~sync_i;
      SENSE_EDGE_FALL: evt = prev_q & ~sync_i;
      SENSE_LVL_HI:    evt = sync_i;
      SENSE_EDGE_RISE: evt = ~prev_q & sync_i;
      default:         evt = 1'b0;
    endcase
  end

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= evt | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt) |=> !pend_o);

  p_event_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> pend_o);

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt && !clr_i) |=> $stable(pend_o));

endmodule

// File: rtl/exti_regs.sv
module exti_regs
  import exti_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LAYOUT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pend_i,
  output sense_e            mode_o,
  output logic              en_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(reg_offset(LAYOUT, REG_CTRL));
  localparam logic [ADDR_W-1:0] OFF_PEND = ADDR_W'(reg_offset(LAYOUT, REG_PEND));
  localparam logic [ADDR_W-1:0] OFF_EN   = ADDR_W'(reg_offset(LAYOUT, REG_EN));

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] en_q;
  logic hit_ctrl, hit_pend, hit_en;

  assign hit_ctrl = (addr_i == OFF_CTRL);
  assign hit_pend = (addr_i == OFF_PEND);
  assign hit_en   = (addr_i == OFF_EN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      en_q   <= '0;
    end else if (wr_en_i) begin
      if (hit_ctrl) ctrl_q <= wdata_i;
      if (hit_en)   en_q   <= wdata_i;
    end
  end

  assign clr_o  = wr_en_i & hit_pend & wdata_i[0];
  assign mode_o = sense_e'(ctrl_q[1:0]);
  assign en_o   = en_q[0];

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl)      rdata_o = ctrl_q;
    else if (hit_pend) rdata_o = {{(DATA_W-1){1'b0}}, pend_i};
    else if (hit_en)   rdata_o = en_q;
  end

  p_ctrl_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_ctrl) |=> (ctrl_q == $past(wdata_i)));

  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit_ctrl && !hit_en) |=> ($stable(ctrl_q) && $stable(en_q)));

endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
  import exti_pkg::*;
#(
  parameter int   ADDR_W      = 8,
  parameter int   LAYOUT      = 0,
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);

  logic   pin_sync;
  logic   pend;
  logic   clr;
  logic   en;
  sense_e mode;

  exti_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  exti_detect #(.IDLE_VAL(PIN_IDLE)) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(pin_sync),
    .mode_i(mode),
    .clr_i (clr),
    .pend_o(pend)
  );

  exti_regs #(.ADDR_W(ADDR_W), .LAYOUT(LAYOUT)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .wdata_i(wdata_i),
    .pend_i (pend),
    .mode_o (mode),
    .en_o   (en),
    .clr_o  (clr),
    .rdata_o(rdata_o)
  );

  assign irq_o = pend & en;

  p_gate_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && $rose(pend)) |-> !irq_o);

endmodule

// File: tb/exti_ctrl_test.sv
module exti_ctrl_test;

  typedef struct {
    int          kind;   // 0 uut rdata, 1 alt rdata, 2 uut irq, 3 alt irq
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_i = 1'b1;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  exti_ctrl #(.LAYOUT(0)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_a), .irq_o(irq_a)
  );

  exti_ctrl #(.LAYOUT(1)) uut_alt (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_b), .irq_o(irq_b)
  );

  // monitor: compares everything queued for this sample point
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = rdata_a;
        1: act = rdata_b;
        2: act = {31'b0, irq_a};
        default: act = {31'b0, irq_b};
      endcase
      total++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h (kind %0d)", it.req, act, it.exp, it.kind);
      end
    end
  end

  task automatic push_chk(int kind, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic rd(int kind, logic [7:0] a, logic [31:0] exp, string req);
    addr_i = a;
    push_chk(kind, exp, req);
    @(negedge clk_i); #1;
  endtask

  task automatic irq_chk(int kind, logic exp, string req);
    push_chk(kind, {31'b0, exp}, req);
    @(negedge clk_i); #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk_i); #1;
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic set_pin(logic v);
    @(posedge clk_i); #1;
    pin_i = v;
    repeat (4) @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);
    #1;

    // R1 reset state
    rd(0, 8'h00, 32'h0, "R1 ctrl");
    rd(0, 8'h04, 32'h0, "R1 pend");
    rd(0, 8'h08, 32'h0, "R1 en");
    irq_chk(2, 1'b0, "R1 irq");
    rd(1, 8'h0C, 32'h0, "R1 alt ctrl");
    rd(1, 8'h40, 32'h0, "R1 alt en");

    // R8 full-width readback
    wr(8'h00, 32'hA5A5_0000);
    rd(0, 8'h00, 32'hA5A5_0000, "R8 ctrl");
    wr(8'h08, 32'h1234_5670);
    rd(0, 8'h08, 32'h1234_5670, "R8 en");
    wr(8'h08, 32'h0000_0001);

    // R11 latency, R2 low level mode
    @(posedge clk_i); #1 pin_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i); #1;
    irq_chk(2, 1'b0, "R11 not before third edge");
    @(posedge clk_i); #1;
    irq_chk(2, 1'b1, "R11 third edge / R2 low level");
    set_pin(1'b1);
    irq_chk(2, 1'b1, "R5 sticky after pin released");
    wr(8'h04, 32'h0);
    rd(0, 8'h04, 32'h1, "R5 write zero no effect");
    wr(8'h04, 32'hFFFF_FFFF);
    rd(0, 8'h04, 32'h0, "R5 w1c");
    irq_chk(2, 1'b0, "R5 irq after clear");

    // R3 rising edge
    wr(8'h00, 32'hA5A5_0003);
    rd(0, 8'h00, 32'hA5A5_0003, "R8 ctrl after mode rewrite");
    set_pin(1'b0);
    irq_chk(2, 1'b0, "R3 rising ignores fall");
    set_pin(1'b1);
    irq_chk(2, 1'b1, "R3 rising edge sets");
    wr(8'h04, 32'h1);
    irq_chk(2, 1'b0, "R3 clear");

    // R3 falling edge
    wr(8'h00, 32'hA5A5_0001);
    set_pin(1'b0);
    irq_chk(2, 1'b1, "R3 falling edge sets");
    wr(8'h04, 32'h1);
    set_pin(1'b1);
    irq_chk(2, 1'b0, "R3 falling ignores rise");

    // R4 high level
    wr(8'h00, 32'hA5A5_0002);
    repeat (2) @(posedge clk_i);
    #1;
    irq_chk(2, 1'b1, "R2 high level");
    wr(8'h04, 32'h1);
    rd(0, 8'h04, 32'h1, "R4 clear while held");
    set_pin(1'b0);
    rd(0, 8'h04, 32'h1, "R4 still pending after drop");
    wr(8'h04, 32'h1);
    rd(0, 8'h04, 32'h0, "R4 clear after drop");

    // R7 latch while disabled
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0000_0003);
    set_pin(1'b1);
    irq_chk(2, 1'b0, "R7 gated");
    rd(0, 8'h04, 32'h1, "R7 latched while disabled");
    wr(8'h08, 32'h1);
    irq_chk(2, 1'b1, "R7 enable releases");
    wr(8'h04, 32'h1);

    // R6 event beats clear
    set_pin(1'b0);
    @(posedge clk_i); #1 pin_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i); #1;
    addr_i = 8'h04; wdata_i = 32'h1; wr_en_i = 1'b1;
    @(posedge clk_i); #1 wr_en_i = 1'b0;
    rd(0, 8'h04, 32'h1, "R6 event wins");
    wr(8'h04, 32'h1);
    rd(0, 8'h04, 32'h0, "R6 later clear");

    // R9 / R10 layouts
    wr(8'h0C, 32'hC0DE_0003);
    rd(1, 8'h0C, 32'hC0DE_0003, "R9 alt ctrl");
    rd(0, 8'h0C, 32'h0, "R10 uut unmapped read");
    rd(0, 8'h00, 32'h0000_0003, "R10 uut ctrl untouched");
    rd(1, 8'h00, 32'h0, "R9 alt ignores 0x00");
    wr(8'h10, 32'h1);
    rd(1, 8'h10, 32'h0, "R9 alt pend cleared");
    set_pin(1'b0);
    set_pin(1'b1);
    rd(1, 8'h10, 32'h1, "R9 alt pend at 0x10");
    irq_chk(3, 1'b0, "R7 alt gated");
    wr(8'h40, 32'h1);
    rd(1, 8'h40, 32'h1, "R9 alt en at 0x40");
    irq_chk(3, 1'b1, "R9 alt irq");
    rd(0, 8'h40, 32'h0, "R10 uut 0x40 unmapped");
    rd(0, 8'h08, 32'h1, "R10 uut en untouched");
    rd(1, 8'h08, 32'h0, "R10 alt 0x08 unmapped");

    done = 1'b1;
    @(negedge clk_i);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule